// File: doc/BRIEF.md
# Variable-Length List Column Writer

The block turns two streams into the two memory buffers of a columnar list column. One stream carries one length per list, from 0 to 255. The other stream carries the list elements as byte lanes, and any subset of the lanes in a transfer may be valid. The block writes an offsets buffer that holds, for every list, the position of that list's first element. It also writes a values buffer that holds every valid element back to back, with no gaps.

Offsets come from a running sum of the lengths. Valid element lanes are packed into full 512-bit bus words. Both buffers go out as burst writes on one shared memory write port. The port has three channels: a command channel that carries the address and the beat count, a data channel that carries the data, the byte strobes and a last flag, and a response channel. When both streams have ended, the partial words that remain are flushed with byte strobes. A done flag then reports the number of lists and the number of elements once every burst has been acknowledged. The two base addresses must be aligned to the bus word size and must stay stable during a run. A new run starts with a reset.

Top module: `list_column_writer`

## Requirements
- R1: The offsets buffer holds 32-bit little-endian entries, 16 per bus word, starting at the offsets base. Entry 0 is 0, and entry i equals the sum of the lengths of lists 0 to i-1. After the list marked last, one extra entry equal to the total element count is written.
- R2: Every element lane whose mask bit is set is written into the values buffer. Elements are placed in arrival order, and within a transfer in increasing lane order. They start at the values base and leave no gaps, whatever the mask pattern.
- R3: The final partial word of each buffer is written with strobes only on its valid bytes. No byte past the final offset entry or past the last element is written.
- R4: Every write command asks for between 1 and 64 beats.
- R5: No write burst crosses a 4096-byte address boundary.
- R6: Each burst carries exactly the number of data beats that its command announced. The last flag is high on the final beat only, and no data beat appears without a command that covers it.
- R7: Done rises only after the final offset, the final element and every write response have been seen. It then stays high, reports the list count and the element total, and no further command or data is issued.
- R8: After reset, both input streams are ready, no command or data is valid, and done is low.
- R9: A command or data beat that is offered and not accepted stays offered, unchanged, until it is accepted.
- R10: Zero-length lists produce equal consecutive offsets. Element transfers with no valid lane are accepted and write nothing. A run with only empty lists writes no values bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| len_valid | input | 1 | Length transfer offered |
| len_ready | output | 1 | Length transfer accepted |
| len_data | input | LEN_W | List length |
| len_last | input | 1 | This length belongs to the final list |
| elem_valid | input | 1 | Element transfer offered |
| elem_ready | output | 1 | Element transfer accepted |
| elem_data | input | LANES*8 | Element bytes, lane i in bits 8i+7..8i |
| elem_mask | input | LANES | Per-lane valid bits |
| elem_last | input | 1 | Final element transfer |
| off_base | input | ADDR_W | Byte address of the offsets buffer |
| val_base | input | ADDR_W | Byte address of the values buffer |
| cmd_valid | output | 1 | Write command offered |
| cmd_ready | input | 1 | Write command accepted |
| cmd_addr | output | ADDR_W | Burst start byte address |
| cmd_beats | output | clog2(MAX_BEATS+1) | Beats in the burst |
| wd_valid | output | 1 | Write data beat offered |
| wd_ready | input | 1 | Write data beat accepted |
| wd_data | output | BUS_W | Write data |
| wd_strb | output | BUS_W/8 | Byte strobes |
| wd_last | output | 1 | Final beat of the burst |
| rsp_valid | input | 1 | Write response for one burst |
| rsp_ready | output | 1 | Always high |
| done | output | 1 | All writes acknowledged |
| done_lists | output | OFF_W | Number of lists written |
| done_elems | output | OFF_W | Number of elements written |

## Verification
A wrong running sum or a slot index that slips in the offset packer shows up in memory as a wrong offset entry at that list's position, in the burst that carries that word. A compaction or fill-level error moves every later values byte, so the first wrong byte points to the transfer that caused it. A beat counter that drifts breaks the last-flag relation on the very beat where it drifts. A missed flush or a lost response shows either as bytes missing at the tail or as done never rising.

// File: rtl/list_column_writer.sv
module list_column_writer #(
  parameter int LANES     = 64,
  parameter int BUS_W     = 512,
  parameter int MAX_BEATS = 64,
  parameter int ADDR_W    = 48,
  parameter int OFF_W     = 32,
  parameter int LEN_W     = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          len_valid,
  output logic                          len_ready,
  input  logic [LEN_W-1:0]              len_data,
  input  logic                          len_last,
  input  logic                          elem_valid,
  output logic                          elem_ready,
  input  logic [LANES*8-1:0]            elem_data,
  input  logic [LANES-1:0]              elem_mask,
  input  logic                          elem_last,
  input  logic [ADDR_W-1:0]             off_base,
  input  logic [ADDR_W-1:0]             val_base,
  output logic                          cmd_valid,
  input  logic                          cmd_ready,
  output logic [ADDR_W-1:0]             cmd_addr,
  output logic [$clog2(MAX_BEATS+1)-1:0] cmd_beats,
  output logic                          wd_valid,
  input  logic                          wd_ready,
  output logic [BUS_W-1:0]              wd_data,
  output logic [BUS_W/8-1:0]            wd_strb,
  output logic                          wd_last,
  input  logic                          rsp_valid,
  output logic                          rsp_ready,
  output logic                          done,
  output logic [OFF_W-1:0]              done_lists,
  output logic [OFF_W-1:0]              done_elems
);
  localparam int BB     = BUS_W / 8;
  localparam int LB     = $clog2(BB);
  localparam int OPW    = BUS_W / OFF_W;
  localparam int OIW    = $clog2(OPW);
  localparam int PW     = $clog2(MAX_BEATS);
  localparam int CNTW   = PW + 1;
  localparam int BW     = $clog2(MAX_BEATS + 1);
  localparam int PAGE_W = 4096 / BB;
  localparam int PGW    = $clog2(PAGE_W);
  localparam int TW     = LB + 2;
  localparam int EW     = BB + BUS_W;

  function automatic logic [BB-1:0] low_mask(input int n);
    logic [BB-1:0] m;
    for (int b = 0; b < BB; b++) m[b] = (b < n);
    return m;
  endfunction

  // word queues: index 0 offsets, 1 values
  logic [EW-1:0]   mem [2][MAX_BEATS];
  logic [PW-1:0]   wp [2];
  logic [PW-1:0]   rp [2];
  logic [CNTW-1:0] cnt [2];
  logic [EW-1:0]   pword [2];
  logic [1:0]      push, pop, space, fin, avail;

  // offsets path
  logic [OFF_W-1:0] run_sum, n_lists;
  logic [BUS_W-1:0] opack, opack_n;
  logic [OIW-1:0]   oidx;
  logic             len_fin, len_over, len_acc, o_go;

  assign len_ready = !len_fin && !len_over && space[0];
  assign len_acc   = len_valid && len_ready;
  assign o_go      = len_acc || (len_fin && space[0]);
  assign push[0]   = o_go && (len_fin || oidx == OIW'(OPW - 1));

  always_comb begin
    opack_n = opack;
    opack_n[oidx*OFF_W +: OFF_W] = run_sum;
  end

  assign pword[0] = {len_fin ? low_mask((int'(oidx) + 1) * (OFF_W / 8)) : {BB{1'b1}}, opack_n};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_sum  <= '0;
      n_lists  <= '0;
      opack    <= '0;
      oidx     <= '0;
      len_fin  <= 1'b0;
      len_over <= 1'b0;
    end else begin
      if (o_go) begin
        opack <= push[0] ? '0 : opack_n;
        oidx  <= push[0] ? '0 : oidx + 1'b1;
      end
      if (len_acc) begin
        run_sum <= run_sum + OFF_W'(len_data);
        n_lists <= n_lists + 1'b1;
        len_fin <= len_last;
      end else if (len_fin && space[0]) begin
        len_fin  <= 1'b0;
        len_over <= 1'b1;
      end
    end
  end

  // values path
  logic [BUS_W-1:0]   vacc;
  logic [LB-1:0]      vfill;
  logic               vflush, val_over, e_acc, vfull;
  logic [2*BUS_W-1:0] wide;
  logic [TW-1:0]      total, rem;

  always_comb begin
    int pos;
    wide = {{BUS_W{1'b0}}, vacc};
    pos  = int'(vfill);
    for (int i = 0; i < LANES; i++) begin
      if (elem_mask[i]) begin
        wide[pos*8 +: 8] = elem_data[i*8 +: 8];
        pos++;
      end
    end
    total = TW'(pos);
  end

  assign vfull      = total >= TW'(BB);
  assign rem        = vfull ? total - TW'(BB) : total;
  assign elem_ready = !vflush && !val_over && space[1];
  assign e_acc      = elem_valid && elem_ready;
  assign push[1]    = (e_acc && vfull) || (vflush && space[1]);
  assign pword[1]   = vflush ? {low_mask(int'(vfill)), vacc}
                             : {{BB{1'b1}}, wide[BUS_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vacc     <= '0;
      vfill    <= '0;
      vflush   <= 1'b0;
      val_over <= 1'b0;
    end else if (e_acc) begin
      vacc  <= vfull ? wide[2*BUS_W-1:BUS_W] : wide[BUS_W-1:0];
      vfill <= LB'(rem);
      if (elem_last) begin
        if (rem != '0) vflush <= 1'b1;
        else           val_over <= 1'b1;
      end
    end else if (vflush && space[1]) begin
      vacc     <= '0;
      vfill    <= '0;
      vflush   <= 1'b0;
      val_over <= 1'b1;
    end
  end

  // queues
  for (genvar b = 0; b < 2; b++) begin : g_q
    assign space[b] = cnt[b] != CNTW'(MAX_BEATS);
    always_ff @(posedge clk) begin
      if (push[b]) mem[b][wp[b]] <= pword[b];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wp[b]  <= '0;
        rp[b]  <= '0;
        cnt[b] <= '0;
      end else begin
        if (push[b]) wp[b] <= wp[b] + 1'b1;
        if (pop[b])  rp[b] <= rp[b] + 1'b1;
        if (push[b] && !pop[b])      cnt[b] <= cnt[b] + 1'b1;
        else if (!push[b] && pop[b]) cnt[b] <= cnt[b] - 1'b1;
      end
    end
  end

  // write engine
  typedef enum logic [1:0] {S_IDLE, S_CMD, S_DATA} st_t;
  st_t              st;
  logic             sel, prio, pick;
  logic [BW-1:0]    left;
  logic [ADDR_W-1:0] boff [2];
  logic [ADDR_W-1:0] acur [2];
  logic [BW-1:0]    nb [2];
  logic [15:0]      outst;

  assign fin[0] = len_over;
  assign fin[1] = val_over;

  always_comb begin
    for (int b = 0; b < 2; b++) begin
      int lim, c;
      acur[b] = (b == 1 ? val_base : off_base) + boff[b];
      lim = PAGE_W - int'(acur[b][LB +: PGW]);
      if (lim > MAX_BEATS) lim = MAX_BEATS;
      c = int'(cnt[b]);
      avail[b] = (c >= lim) || (fin[b] && c != 0);
      nb[b] = BW'((c < lim) ? c : lim);
    end
  end

  assign pick      = avail[1] && (!avail[0] || prio);
  assign cmd_valid = st == S_CMD;
  assign wd_valid  = st == S_DATA;
  assign {wd_strb, wd_data} = mem[sel][rp[sel]];
  assign wd_last   = left == BW'(1);
  assign pop[0]    = wd_valid && wd_ready && !sel;
  assign pop[1]    = wd_valid && wd_ready && sel;
  assign rsp_ready = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      sel       <= 1'b0;
      prio      <= 1'b0;
      left      <= '0;
      cmd_addr  <= '0;
      cmd_beats <= '0;
      boff[0]   <= '0;
      boff[1]   <= '0;
    end else begin
      case (st)
        S_IDLE: if (|avail) begin
          sel       <= pick;
          prio      <= !pick;
          cmd_addr  <= acur[pick];
          cmd_beats <= nb[pick];
          st        <= S_CMD;
        end
        S_CMD: if (cmd_ready) begin
          boff[sel] <= boff[sel] + (ADDR_W'(cmd_beats) << LB);
          left      <= cmd_beats;
          st        <= S_DATA;
        end
        S_DATA: if (wd_ready) begin
          left <= left - 1'b1;
          if (left == BW'(1)) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) outst <= '0;
    else if ((cmd_valid && cmd_ready) && !rsp_valid) outst <= outst + 1'b1;
    else if (!(cmd_valid && cmd_ready) && rsp_valid) outst <= outst - 1'b1;
  end

  assign done = len_over && val_over && cnt[0] == '0 && cnt[1] == '0 &&
                st == S_IDLE && outst == '0;
  assign done_lists = n_lists;
  assign done_elems = run_sum;
endmodule

// File: rtl/list_column_writer_chk.sv
module list_column_writer_chk #(
  parameter int BUS_W     = 512,
  parameter int MAX_BEATS = 64,
  parameter int ADDR_W    = 48
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           cmd_valid,
  input logic                           cmd_ready,
  input logic [ADDR_W-1:0]              cmd_addr,
  input logic [$clog2(MAX_BEATS+1)-1:0] cmd_beats,
  input logic                           wd_valid,
  input logic                           wd_ready,
  input logic [BUS_W-1:0]               wd_data,
  input logic [BUS_W/8-1:0]             wd_strb,
  input logic                           wd_last,
  input logic                           done
);
  localparam int BB = BUS_W / 8;
  localparam int BW = $clog2(MAX_BEATS + 1);

  logic [BW-1:0] rem;
  always_ff @(posedge clk) begin
    if (!rst_n) rem <= '0;
    else if (cmd_valid && cmd_ready) rem <= cmd_beats;
    else if (wd_valid && wd_ready) rem <= rem - 1'b1;
  end

  p_beats_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_beats != '0 && int'(cmd_beats) <= MAX_BEATS));

  p_no_page_cross_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (int'(cmd_addr[11:0]) + int'(cmd_beats) * BB <= 4096));

  p_last_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wd_valid |-> (wd_last == (rem == BW'(1))));

  p_data_covered_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wd_valid |-> rem != '0);

  p_cmd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_beats)));

  p_data_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_valid && !wd_ready) |=> (wd_valid && $stable(wd_data) && $stable(wd_strb) && $stable(wd_last)));

  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!cmd_valid && !wd_valid));
endmodule

bind list_column_writer list_column_writer_chk #(
  .BUS_W(BUS_W), .MAX_BEATS(MAX_BEATS), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/tb_list_column_writer.sv
module tb_list_column_writer;
  localparam int LANES = 64, BUS_W = 512, BB = 64, ADDR_W = 48, OFF_W = 32, MAXB = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic len_valid = 1'b0, len_ready, len_last = 1'b0;
  logic [7:0] len_data = '0;
  logic elem_valid = 1'b0, elem_ready, elem_last = 1'b0;
  logic [LANES*8-1:0] elem_data = '0;
  logic [LANES-1:0] elem_mask = '0;
  logic [ADDR_W-1:0] off_base = '0, val_base = '0;
  logic cmd_valid, cmd_ready, wd_valid, wd_ready, wd_last, rsp_valid, rsp_ready, done;
  logic [ADDR_W-1:0] cmd_addr;
  logic [6:0] cmd_beats;
  logic [BUS_W-1:0] wd_data;
  logic [BB-1:0] wd_strb;
  logic [OFF_W-1:0] done_lists, done_elems;

  list_column_writer dut (.*);

  always #5 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  int lens[$];
  int mode;
  bit bp;
  logic [7:0] mem [longint];
  logic [63:0] xs;

  // memory responder
  int pend, brem;
  longint wa;
  logic [31:0] lf;
  always @(posedge clk) begin
    if (!rst_n) begin
      cmd_ready <= 1'b0; wd_ready <= 1'b0; rsp_valid <= 1'b0;
      pend = 0; brem = 0; lf <= 32'h1234_5679;
    end else begin
      lf <= {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      if (rsp_valid) pend--;
      if (cmd_valid && cmd_ready) begin
        n_tests++;
        if (cmd_beats < 1 || cmd_beats > MAXB) begin
          n_fail++; $display("FAIL R4: beats=%0d expected 1..%0d", cmd_beats, MAXB);
        end
        n_tests++;
        if (int'(cmd_addr[11:0]) + int'(cmd_beats) * BB > 4096) begin
          n_fail++; $display("FAIL R5: addr=%h beats=%0d crosses 4KiB (expected none)", cmd_addr, cmd_beats);
        end
        if (brem != 0) begin
          n_fail++; $display("FAIL R6: new command with %0d beats left, expected 0", brem);
        end
        wa = longint'(cmd_addr); brem = int'(cmd_beats);
      end
      if (wd_valid && wd_ready) begin
        for (int b = 0; b < BB; b++) if (wd_strb[b]) mem[wa + b] = wd_data[b*8 +: 8];
        wa += BB; brem--;
        if (wd_last != (brem == 0)) begin
          n_fail++; $display("FAIL R6: last=%0b expected %0b", wd_last, brem == 0);
        end
        if (wd_last) pend++;
      end
      cmd_ready <= !bp || lf[0] || lf[3];
      wd_ready  <= !bp || lf[5] || lf[9];
      rsp_valid <= pend > 0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  function automatic logic [7:0] ev(int k);
    return 8'((k * 7) + (k >> 8) + 3);
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(longint ob, longint vb);
    rst_n = 1'b0; len_valid = 1'b0; elem_valid = 1'b0;
    off_base = ADDR_W'(ob); val_base = ADDR_W'(vb);
    mem.delete();
    xs = 64'h9E37_79B9_7F4A_7C15;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic feed_lens();
    for (int i = 0; i < lens.size(); i++) begin
      @(negedge clk);
      len_valid = 1'b1; len_data = 8'(lens[i]); len_last = (i == lens.size() - 1);
      #1;
      while (!len_ready) begin @(negedge clk); #1; end
      @(posedge clk);
    end
    @(negedge clk);
    len_valid = 1'b0;
  endtask

  function automatic logic [63:0] next_mask(int beat);
    if (mode == 0) return '1;
    if (mode == 2) return (beat % 5 == 4) ? 64'h0 : (64'h1 << (beat % 64));
    xs ^= xs << 13; xs ^= xs >> 7; xs ^= xs << 17;
    return xs;
  endfunction

  task automatic feed_elems(int total);
    int idx = 0, beat = 0;
    forever begin
      logic [63:0] m;
      int pc;
      bit last;
      m = next_mask(beat);
      for (int b = 63; b >= 0; b--)
        if ($countones(m) > total - idx && m[b]) m[b] = 1'b0;
      pc = $countones(m);
      last = (idx + pc == total);
      @(negedge clk);
      elem_valid = 1'b1; elem_mask = m; elem_last = last;
      begin
        int k = idx;
        for (int i = 0; i < LANES; i++) begin
          if (m[i]) begin elem_data[i*8 +: 8] = ev(k); k++; end
          else elem_data[i*8 +: 8] = 8'hEE;
        end
      end
      #1;
      while (!elem_ready) begin @(negedge clk); #1; end
      @(posedge clk);
      idx += pc; beat++;
      if (last) break;
    end
    @(negedge clk);
    elem_valid = 1'b0;
  endtask

  function automatic longint rd32(longint a);
    longint v = 0;
    for (int b = 3; b >= 0; b--) begin
      if (!mem.exists(a + b)) return -1;
      v = (v << 8) | longint'(mem[a + b]);
    end
    return v;
  endfunction

  task automatic run_case(string tag, longint ob, longint vb);
    int total = 0, n = lens.size(), cyc = 0, bad_off = -1, bad_val = -1;
    longint sum = 0, act = 0, expv = 0;
    foreach (lens[i]) total += lens[i];
    do_reset(ob, vb);
    fork
      feed_lens();
      feed_elems(total);
    join
    while (!done && cyc < 40000) begin @(negedge clk); cyc++; end
    $display("[TB] case %s: %0d lists, %0d elements", tag, n, total);
    check(done, "R7", "done raised", done, 1);
    check(done_lists == n, "R7", "list count", done_lists, n);
    check(done_elems == total, "R7", "element count", done_elems, total);
    for (int i = 0; i <= n; i++) begin
      longint g = rd32(ob + 4 * i);
      if (bad_off < 0 && g != sum) begin bad_off = i; act = g; expv = sum; end
      if (i < n) sum += lens[i];
    end
    check(bad_off < 0, "R1", $sformatf("offset entry %0d", bad_off), act, expv);
    for (int k = 0; k < total; k++) begin
      if (bad_val < 0 && (!mem.exists(vb + k) || mem[vb + k] !== ev(k))) begin
        bad_val = k; act = mem.exists(vb + k) ? longint'(mem[vb + k]) : -1; expv = ev(k);
      end
    end
    check(bad_val < 0, "R2", $sformatf("values byte %0d", bad_val), act, expv);
    check(!mem.exists(ob + 4 * (n + 1)), "R3", "byte after final offset written", mem.exists(ob + 4 * (n + 1)), 0);
    check(!mem.exists(vb + total), "R3", "byte after last element written", mem.exists(vb + total), 0);
  endtask

  task automatic t_reset();
    do_reset(64'h1000, 64'h2000);
    #1;
    check(!cmd_valid && !wd_valid, "R8", "command/data idle after reset", cmd_valid | wd_valid, 0);
    check(!done, "R8", "done low after reset", done, 0);
    check(len_ready && elem_ready, "R8", "streams ready after reset", len_ready & elem_ready, 1);
  endtask

  task automatic t_basic();
    lens = '{3, 0, 5}; mode = 0; bp = 0;
    run_case("basic", 64'h10000, 64'h20000);
  endtask

  task automatic t_scattered();
    lens.delete();
    for (int i = 0; i < 20; i++) lens.push_back((i * 13) % 40);
    mode = 1; bp = 1;
    run_case("scattered lanes R2", 64'h30040, 64'h50000);
  endtask

  task automatic t_big();
    lens.delete();
    for (int i = 0; i < 300; i++) lens.push_back((i * 37 + 11) % 256);
    lens[5] = 255; lens[6] = 0;
    mode = 1; bp = 1;
    run_case("long run, page crossings R4 R5", 64'h40F80, 64'h317C0);
  endtask

  task automatic t_empty();
    lens = '{0, 0}; mode = 0; bp = 0;
    run_case("empty lists R10", 64'h60000, 64'h70000);
    check(!mem.exists(64'h70000), "R10", "values byte written for empty run", mem.exists(64'h70000), 0);
    check(rd32(64'h60004) == 0 && rd32(64'h60008) == 0, "R10", "zero-length offsets", rd32(64'h60008), 0);
  endtask

  task automatic t_sparse();
    lens.delete();
    for (int i = 0; i < 16; i++) lens.push_back(4);
    mode = 2; bp = 1;
    run_case("single-lane and empty transfers R10", 64'h80000, 64'h90000);
    check(rd32(64'h80000 + 64) == 64, "R1", "17th offset in second word", rd32(64'h80000 + 64), 64);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_scattered();
    t_big();
    t_empty();
    t_sparse();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule